// File: doc/BRIEF.md
# HDLC Frame Receiver with CRC Check

This block receives a serial HDLC line. Each cycle that the bit-enable strobe is high, it takes one line bit. It looks for the flag octet 0x7E to find where frames start and end. It removes the zeros that the transmitter inserted after runs of ones, and it builds octets least-significant bit first. Every octet of a frame goes out on a byte stream: one cycle of valid per octet, with markers on the first and last octet. The frame check sequence octets are included in this stream.

The frame check sequence is tested with a CCITT polynomial. A two-bit mode input selects the 16-bit or the 32-bit polynomial, and the mode is sampled at the flag that opens each frame. When the closing flag arrives, the block posts a one-cycle status with a CRC-error bit. If the interrupt enable is set, it also pulses a frame-received interrupt. A saturating counter records how many frames failed the check.

The check cannot be turned off. A frame that fails is still delivered in full, including its check octets, and it is still closed normally. The flag that closes a bad frame also opens the next frame, so a frame that follows back-to-back is received. A run of seven ones aborts the frame in progress, and the receiver then waits for a new flag.

Top module: `hdlc_rx_top`

## Requirements
- R1: After reset, and after an abort, no octet, status or interrupt is produced until a 0x7E flag has been seen. The reset state of every output is zero.
- R2: A zero that follows five consecutive ones is dropped. Payload octets 0xFF and 0x7E therefore arrive unchanged.
- R3: Octets are assembled with the first received bit as bit 0. Every octet of the frame, including the check octets, is output in order. `dat_sof` is high on the first octet and `dat_eof` is high on the last octet, and `dat_eof` appears in the same cycle as `stat_valid`.
- R4: A `crc_mode` of 2'b00 selects x^16+x^12+x^5+1, with a preset of 0xFFFF and a good residue of 0xF0B8. A `crc_mode` of 2'b10 selects the 32-bit CCITT polynomial, with a preset of 0xFFFFFFFF and a good residue of 0xDEBB20E3. The reserved value 2'b01 behaves as 2'b00 and the reserved value 2'b11 behaves as 2'b10. The mode is sampled at the flag that opens the frame.
- R5: A closing flag that ends a frame of at least one octet gives a one-cycle `stat_valid`. `stat_crc_err` is 1 when the residue is wrong or when the frame length is not a whole number of octets. On a good frame the error counter does not change.
- R6: A frame that fails the check still outputs all of its octets, including the received check octets, and is still closed with `dat_eof`. The error counter goes up by one.
- R7: `irq` pulses together with `stat_valid` for every closed frame, good or bad, when `irq_en` is 1. It is never pulsed at any other time.
- R8: `crc_err_count` stops at 2^CNT_W-1 and does not wrap.
- R9: Seven consecutive ones abort the frame. The octet still held back is dropped, `stat_valid` pulses with `stat_abort`=1 and `stat_crc_err`=0, no interrupt is raised, and the counter does not change.
- R10: A closing flag also serves as the opening flag of the next frame, so a frame right after a bad frame is received correctly. Flags with no octets between them produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | When high, `rx_bit` holds a new line bit |
| rx_bit | input | 1 | Serial line data |
| crc_mode | input | 2 | Check polynomial select (see R4) |
| irq_en | input | 1 | Enables the frame-received interrupt |
| dat_valid | output | 1 | One-cycle strobe for a received octet |
| dat_byte | output | 8 | Received octet |
| dat_sof | output | 1 | Octet is the first of its frame |
| dat_eof | output | 1 | Octet is the last of its frame |
| stat_valid | output | 1 | One-cycle strobe for end-of-frame status |
| stat_crc_err | output | 1 | Frame failed the check or was not octet aligned |
| stat_abort | output | 1 | Frame ended by an abort sequence |
| irq | output | 1 | Frame-received interrupt pulse |
| crc_err_count | output | CNT_W | Saturating count of failed frames |

## Verification
The CRC register is preset at every flag. If a preset were wrong or a residue constant were wrong, the fault would show at the first closing flag: the status would flag a good frame as an error and the counter would move. If the ones-run tracker were corrupted, stuffed zeros would stay in the data or flags would be missed. This shows up within one octet as a wrong `dat_byte`, or as octets arriving while the receiver should be idle. If the held-back octet were mishandled, the first and last markers would sit on the wrong octets, or an aborted frame would leak its last octet. Both are visible in the same frame.

// File: rtl/hdlc_rx_pkg.sv
`timescale 1ns/1ps
// Shared constants and helpers for the HDLC receiver.
// Assumes the bit-reflected, least-significant-bit-first CRC convention.
package hdlc_rx_pkg;
    localparam int OCTET     = 8;
    localparam int STUFF_RUN = 5;                 // ones before a stuffed zero
    localparam int FLAG_RUN  = STUFF_RUN + 1;     // ones inside a flag
    localparam int ABORT_RUN = STUFF_RUN + 2;     // ones that abort a frame
    localparam int CRC_W     = 32;

    localparam logic [CRC_W-1:0] POLY_NARROW = 32'h0000_8408;
    localparam logic [CRC_W-1:0] POLY_WIDE   = 32'hEDB8_8320;
    localparam logic [CRC_W-1:0] PRESET_NARROW = 32'h0000_FFFF;
    localparam logic [CRC_W-1:0] PRESET_WIDE   = 32'hFFFF_FFFF;
    localparam logic [15:0]      GOOD_NARROW   = 16'hF0B8;
    localparam logic [CRC_W-1:0] GOOD_WIDE     = 32'hDEBB_20E3;

    // Decodes the mode input; bit 0 values are reserved and do not matter.
    function automatic logic mode_is_wide(input logic [1:0] m);
        return (m == 2'b10) || (m == 2'b11);
    endfunction

    // Advances a reflected CRC register over one octet.
    function automatic logic [CRC_W-1:0] crc_octet(input logic [CRC_W-1:0] c,
                                                  input logic [OCTET-1:0] d,
                                                  input logic wide);
        logic [CRC_W-1:0] r;
        r = c;
        for (int i = 0; i < OCTET; i++) begin
            if (r[0] ^ d[i])
                r = (r >> 1) ^ (wide ? POLY_WIDE : POLY_NARROW);
            else
                r = r >> 1;
        end
        if (!wide)
            r[CRC_W-1:16] = '0;
        return r;
    endfunction
endpackage

// File: rtl/hdlc_line_decode.sv
`timescale 1ns/1ps
// Line decoder: follows the run of ones on the raw line. From that run it
// produces a strobe for each data bit (stuffed zeros are removed), a strobe
// when a flag completes and a strobe when an abort run reaches seven ones.
// Assumes one line bit for each cycle in which bit_en is high.
module hdlc_line_decode
    import hdlc_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic rx_bit,
    output logic data_stb,
    output logic data_bit,
    output logic flag_stb,
    output logic abort_stb
);
    localparam int RUN_W = $clog2(ABORT_RUN + 1);
    localparam logic [RUN_W-1:0] STUFF_V = RUN_W'(STUFF_RUN);
    localparam logic [RUN_W-1:0] FLAG_V  = RUN_W'(FLAG_RUN);
    localparam logic [RUN_W-1:0] ABORT_V = RUN_W'(ABORT_RUN);

    logic [RUN_W-1:0] run_q;

    // Classifies the incoming bit against the ones seen so far.
    always_comb begin
        data_stb  = 1'b0;
        data_bit  = rx_bit;
        flag_stb  = 1'b0;
        abort_stb = 1'b0;
        if (bit_en) begin
            if (rx_bit) begin
                if (run_q < STUFF_V)
                    data_stb = 1'b1;
                else if (run_q == FLAG_V)
                    abort_stb = 1'b1;
            end else begin
                if (run_q == FLAG_V)
                    flag_stb = 1'b1;
                else if (run_q < STUFF_V)
                    data_stb = 1'b1;
            end
        end
    end

    // Counts consecutive ones; the count stops at the abort length.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (bit_en)
            run_q <= rx_bit ? ((run_q == ABORT_V) ? run_q : run_q + 1'b1) : '0;
    end
endmodule

// File: rtl/hdlc_octet_asm.sv
`timescale 1ns/1ps
// Octet assembler: shifts in data bits, first bit first, and flags each
// completed octet in the same cycle as its last bit. Also reports how
// many bits of the next octet it holds. Assumes clear and bit_stb never
// arrive in the same cycle.
module hdlc_octet_asm
    import hdlc_rx_pkg::*;
#(
    localparam int FILL_W = $clog2(OCTET)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              bit_in,
    input  logic              clear,
    output logic              byte_stb,
    output logic [OCTET-1:0]  byte_val,
    output logic [FILL_W-1:0] fill
);
    localparam logic [FILL_W-1:0] LAST_V = FILL_W'(OCTET - 1);

    logic [OCTET-1:0]  sh_q;
    logic [FILL_W-1:0] cnt_q;

    assign byte_val = {bit_in, sh_q[OCTET-1:1]};
    assign byte_stb = bit_stb && (cnt_q == LAST_V);
    assign fill     = cnt_q;

    // Shifts data bits in and keeps the position within the octet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (bit_stb) begin
            sh_q  <= byte_val;
            cnt_q <= (cnt_q == LAST_V) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/hdlc_fcs_check.sv
`timescale 1ns/1ps
// Frame check: presets the CRC register at each flag or abort and samples
// the polynomial choice at that moment. It then folds in every completed
// octet and reports whether the register holds the good residue. Assumes
// the caller reads res_ok before the restart in the same cycle takes hold.
module hdlc_fcs_check
    import hdlc_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             wide_sel,
    input  logic             byte_stb,
    input  logic [OCTET-1:0] byte_val,
    output logic             res_ok
);
    logic [CRC_W-1:0] crc_q;
    logic             wide_q;

    // Compares the register against the residue of the active width.
    always_comb begin
        if (wide_q)
            res_ok = (crc_q == GOOD_WIDE);
        else
            res_ok = (crc_q[15:0] == GOOD_NARROW);
    end

    // Presets on frame boundaries and accumulates completed octets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q  <= PRESET_NARROW;
            wide_q <= 1'b0;
        end else if (restart) begin
            wide_q <= wide_sel;
            crc_q  <= wide_sel ? PRESET_WIDE : PRESET_NARROW;
        end else if (byte_stb) begin
            crc_q  <= crc_octet(crc_q, byte_val, wide_q);
        end
    end
endmodule

// File: rtl/hdlc_err_counter.sv
`timescale 1ns/1ps
// Saturating event counter for frames that failed the check. Assumes at
// most one increment request per cycle.
module hdlc_err_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Adds one per request and stops at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (inc && (count != CNT_MAX))
            count <= count + 1'b1;
    end

    AST_CNT_SATURATED: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_MAX) |=> (count == CNT_MAX)); // R8
    AST_CNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(count)); // R5
endmodule

// File: rtl/hdlc_rx_top.sv
`timescale 1ns/1ps
// HDLC frame receiver: decodes the line, assembles octets and checks the
// CRC. Octets stream out one behind the line, because one octet is held
// back so that the last one can carry the end marker. A status word and
// an optional interrupt are posted at the closing flag. Assumes crc_mode
// is stable around each flag and that bit_en is a single-cycle strobe.
module hdlc_rx_top
    import hdlc_rx_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             rx_bit,
    input  logic [1:0]       crc_mode,
    input  logic             irq_en,
    output logic             dat_valid,
    output logic [7:0]       dat_byte,
    output logic             dat_sof,
    output logic             dat_eof,
    output logic             stat_valid,
    output logic             stat_crc_err,
    output logic             stat_abort,
    output logic             irq,
    output logic [CNT_W-1:0] crc_err_count
);
    localparam int FILL_W = $clog2(OCTET);
    // The flag's leading zero and first five ones enter the assembler.
    localparam logic [FILL_W-1:0] TAIL_FILL = FILL_W'((STUFF_RUN + 1) % OCTET);
    localparam logic [CNT_W-1:0]  CNT_MAX   = '1;

    logic              data_stb, data_bit, flag_stb, abort_stb;
    logic              byte_stb;
    logic [OCTET-1:0]  byte_val;
    logic [FILL_W-1:0] fill;
    logic              res_ok;
    logic              close_bad, err_inc;

    logic              synced_q, pend_v_q, pend_sof_q, first_q;
    logic [OCTET-1:0]  pend_q;

    hdlc_line_decode u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .rx_bit    (rx_bit),
        .data_stb  (data_stb),
        .data_bit  (data_bit),
        .flag_stb  (flag_stb),
        .abort_stb (abort_stb)
    );

    hdlc_octet_asm u_octet (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_stb  (data_stb),
        .bit_in   (data_bit),
        .clear    (flag_stb | abort_stb),
        .byte_stb (byte_stb),
        .byte_val (byte_val),
        .fill     (fill)
    );

    hdlc_fcs_check u_fcs (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (flag_stb | abort_stb),
        .wide_sel (mode_is_wide(crc_mode)),
        .byte_stb (byte_stb),
        .byte_val (byte_val),
        .res_ok   (res_ok)
    );

    // Decides whether a frame that is closing failed the check or alignment.
    always_comb begin
        close_bad = !res_ok || (fill != TAIL_FILL);
        err_inc   = flag_stb && synced_q && pend_v_q && close_bad;
    end

    hdlc_err_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (err_inc),
        .count (crc_err_count)
    );

    // Frame control: sync state, held-back octet, octet and status outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            synced_q     <= 1'b0;
            pend_v_q     <= 1'b0;
            pend_sof_q   <= 1'b0;
            first_q      <= 1'b0;
            pend_q       <= '0;
            dat_valid    <= 1'b0;
            dat_byte     <= '0;
            dat_sof      <= 1'b0;
            dat_eof      <= 1'b0;
            stat_valid   <= 1'b0;
            stat_crc_err <= 1'b0;
            stat_abort   <= 1'b0;
            irq          <= 1'b0;
        end else begin
            dat_valid    <= 1'b0;
            dat_sof      <= 1'b0;
            dat_eof      <= 1'b0;
            stat_valid   <= 1'b0;
            stat_crc_err <= 1'b0;
            stat_abort   <= 1'b0;
            irq          <= 1'b0;
            if (abort_stb) begin
                if (synced_q && pend_v_q) begin
                    stat_valid <= 1'b1;
                    stat_abort <= 1'b1;
                end
                synced_q <= 1'b0;
                pend_v_q <= 1'b0;
            end else if (flag_stb) begin
                if (synced_q && pend_v_q) begin
                    dat_valid    <= 1'b1;
                    dat_byte     <= pend_q;
                    dat_sof      <= pend_sof_q;
                    dat_eof      <= 1'b1;
                    stat_valid   <= 1'b1;
                    stat_crc_err <= close_bad;
                    irq          <= irq_en;
                end
                synced_q <= 1'b1;
                pend_v_q <= 1'b0;
                first_q  <= 1'b1;
            end else if (byte_stb && synced_q) begin
                if (pend_v_q) begin
                    dat_valid <= 1'b1;
                    dat_byte  <= pend_q;
                    dat_sof   <= pend_sof_q;
                end
                pend_q     <= byte_val;
                pend_sof_q <= first_q;
                first_q    <= 1'b0;
                pend_v_q   <= 1'b1;
            end
        end
    end

    AST_EOF_WITH_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_valid && dat_eof) |-> (stat_valid && !stat_abort)); // R3
    AST_IRQ_ON_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (stat_valid && !stat_abort && $past(irq_en))); // R7
    AST_ABORT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && stat_abort) |-> (!dat_valid && !irq && !stat_crc_err)); // R9
    AST_ERR_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && stat_crc_err && ($past(crc_err_count) != CNT_MAX))
        |-> (crc_err_count == $past(crc_err_count) + 1'b1)); // R6
    AST_GOOD_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && !stat_crc_err) |-> $stable(crc_err_count)); // R5
endmodule

// File: tb/tb_hdlc_rx_top.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases plus seeded random frames.
module tb_hdlc_rx_top;
    localparam int CNT_W = 3;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst_n, bit_en, rx_bit, irq_en;
    logic [1:0]       crc_mode;
    logic             dat_valid, dat_sof, dat_eof;
    logic [7:0]       dat_byte;
    logic             stat_valid, stat_crc_err, stat_abort, irq;
    logic [CNT_W-1:0] crc_err_count;

    hdlc_rx_top #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
        .crc_mode(crc_mode), .irq_en(irq_en), .dat_valid(dat_valid),
        .dat_byte(dat_byte), .dat_sof(dat_sof), .dat_eof(dat_eof),
        .stat_valid(stat_valid), .stat_crc_err(stat_crc_err),
        .stat_abort(stat_abort), .irq(irq), .crc_err_count(crc_err_count)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // monitor record
    logic [7:0] got_b [0:63];
    bit         got_s [0:63];
    bit         got_e [0:63];
    int         got_n, stat_n, irq_n;
    bit         st_crc, st_abort;

    // expected frame
    logic [7:0] exp_b [0:63];
    int         exp_n;
    int         exp_cnt = 0;
    bit         cur_wide;
    logic [31:0] run_crc;
    int         tx_ones = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic finish_sim();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(negedge clk) begin
        if (dat_valid) begin
            if (got_n < 64) begin
                got_b[got_n] = dat_byte;
                got_s[got_n] = dat_sof;
                got_e[got_n] = dat_eof;
            end
            got_n++;
        end
        if (stat_valid) begin
            stat_n++;
            st_crc   = stat_crc_err;
            st_abort = stat_abort;
        end
        if (irq) irq_n++;
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "ALL", "watchdog expired", 0, 1);
        finish_sim();
    end

    function automatic logic [31:0] crc_upd(input logic [31:0] c, input logic [7:0] d,
                                            input bit wide);
        logic [31:0] r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ (wide ? 32'hEDB88320 : 32'h00008408);
            else             r = r >> 1;
        end
        return r;
    endfunction

    task automatic send_bit(input bit b);
        @(negedge clk);
        rx_bit = b;
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        if ($urandom % 4 == 0) @(negedge clk);
    endtask

    task automatic send_flag();
        send_bit(1'b0);
        for (int i = 0; i < 6; i++) send_bit(1'b1);
        send_bit(1'b0);
        tx_ones = 0;
    endtask

    task automatic send_data_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            send_bit(b[i]);
            if (b[i]) begin
                tx_ones++;
                if (tx_ones == 5) begin
                    send_bit(1'b0);
                    tx_ones = 0;
                end
            end else begin
                tx_ones = 0;
            end
        end
    endtask

    task automatic send_raw_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) send_bit(b[i]);
        tx_ones = 0;
    endtask

    task automatic clear_mon();
        got_n = 0; stat_n = 0; irq_n = 0; st_crc = 0; st_abort = 0;
    endtask

    task automatic build_frame(input int n, input bit heavy, input bit corrupt);
        logic [7:0]  b;
        logic [31:0] fcs;
        exp_n   = 0;
        run_crc = cur_wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        for (int i = 0; i < n; i++) begin
            if (heavy) b = ($urandom % 2) ? 8'hFF : 8'h7E;
            else       b = 8'($urandom);
            exp_b[exp_n] = b;
            exp_n++;
            run_crc = crc_upd(run_crc, b, cur_wide);
        end
        fcs = ~run_crc;
        for (int k = 0; k < (cur_wide ? 4 : 2); k++) begin
            exp_b[exp_n] = fcs[8*k +: 8];
            exp_n++;
        end
        if (corrupt) begin
            int idx = int'($urandom % n);
            exp_b[idx] = exp_b[idx] ^ 8'(1 << ($urandom % 8));
        end
    endtask

    task automatic send_body();
        for (int i = 0; i < exp_n; i++) send_data_byte(exp_b[i]);
    endtask

    task automatic check_frame(input string req, input bit exp_err, input bit exp_irq);
        int bad = 0;
        int want;
        repeat (3) @(negedge clk);
        chk(got_n == exp_n, req, "octet count", got_n, exp_n);
        for (int i = 0; i < exp_n && i < 64; i++) begin
            if (got_b[i] !== exp_b[i] || got_s[i] != (i == 0) || got_e[i] != (i == exp_n - 1))
                bad++;
        end
        chk(bad == 0, req, "octets and markers (R3)", bad, 0);
        chk(stat_n == 1 && st_abort == 0, req, "one close status", stat_n, 1);
        chk(st_crc == exp_err, req, "crc error bit (R5)", st_crc, exp_err);
        chk(irq_n == int'(exp_irq), req, "interrupt pulses (R7)", irq_n, exp_irq);
        if (exp_err) exp_cnt++;
        want = (exp_cnt > CMAX) ? CMAX : exp_cnt;
        chk(int'(crc_err_count) == want, req, "error counter (R8)", crc_err_count, want);
    endtask

    task automatic run_frame(input string req, input int n, input bit heavy,
                             input bit corrupt, input bit ie, input logic [1:0] next_mode);
        irq_en = ie;
        clear_mon();
        build_frame(n, heavy, corrupt);
        send_body();
        crc_mode = next_mode;
        send_flag();
        check_frame(req, corrupt, ie);
        cur_wide = next_mode[1];
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; bit_en = 1'b0; rx_bit = 1'b0; crc_mode = 2'b00; irq_en = 1'b1;
        clear_mon();
        repeat (3) @(negedge clk);
        chk(!dat_valid && !stat_valid && !irq && crc_err_count == 0 && dat_byte == 0,
            "R1", "reset state", {dat_valid, stat_valid, irq}, 0);
        rst_n = 1'b1;

        // R1: line noise with no flag gives nothing
        for (int i = 0; i < 5; i++) send_raw_byte(8'hA5);
        repeat (3) @(negedge clk);
        chk(got_n == 0 && stat_n == 0, "R1", "output before first flag", got_n + stat_n, 0);

        crc_mode = 2'b00; cur_wide = 1'b0;
        send_flag();
        run_frame("R2", 6, 1'b1, 1'b0, 1'b1, 2'b10);   // stuffing-heavy payload
        run_frame("R4", 5, 1'b0, 1'b0, 1'b1, 2'b01);   // 32-bit frame
        run_frame("R4", 4, 1'b0, 1'b0, 1'b1, 2'b00);   // reserved 01 acts as 16-bit
        run_frame("R6", 5, 1'b0, 1'b1, 1'b1, 2'b11);   // bad CRC, data passed through
        run_frame("R10", 3, 1'b0, 1'b0, 1'b1, 2'b00);  // back-to-back after error, 11 as 32-bit
        run_frame("R7", 4, 1'b0, 1'b0, 1'b0, 2'b00);   // interrupt disabled

        // R10: empty flag pairs give nothing
        clear_mon();
        send_flag();
        send_flag();
        repeat (3) @(negedge clk);
        chk(got_n == 0 && stat_n == 0 && irq_n == 0, "R10", "idle flags silent",
            got_n + stat_n, 0);

        // R5: frame not a whole number of octets
        clear_mon();
        build_frame(3, 1'b0, 1'b0);
        send_body();
        for (int i = 0; i < 3; i++) send_bit(1'b0);
        tx_ones = 0;
        send_flag();
        repeat (3) @(negedge clk);
        chk(stat_n == 1 && st_crc == 1, "R5", "misaligned frame flagged", st_crc, 1);
        exp_cnt++;
        chk(int'(crc_err_count) == ((exp_cnt > CMAX) ? CMAX : exp_cnt), "R5",
            "misaligned frame counted", crc_err_count, exp_cnt);

        // R9: abort after two octets, then noise in hunt
        clear_mon();
        build_frame(4, 1'b0, 1'b0);
        send_data_byte(exp_b[0]);
        send_data_byte(exp_b[1]);
        for (int i = 0; i < 8; i++) send_bit(1'b1);
        for (int i = 0; i < 3; i++) send_raw_byte(8'hA5);
        repeat (3) @(negedge clk);
        chk(got_n == 1 && got_b[0] == exp_b[0], "R9", "only released octet out", got_n, 1);
        chk(stat_n == 1 && st_abort == 1 && st_crc == 0, "R9", "abort status",
            {st_abort, st_crc}, 2);
        chk(irq_n == 0, "R9", "no interrupt on abort", irq_n, 0);
        chk(int'(crc_err_count) == ((exp_cnt > CMAX) ? CMAX : exp_cnt), "R9",
            "counter unchanged", crc_err_count, exp_cnt);

        // random frames
        crc_mode = 2'b00; cur_wide = 1'b0;
        send_flag();
        for (int k = 0; k < 24; k++) begin
            run_frame("R3", 1 + int'($urandom % 10), bit'($urandom % 2),
                      ($urandom % 3) == 0, ($urandom % 4) != 0, 2'($urandom % 4));
        end

        // R8: drive the counter into saturation
        for (int k = 0; k < 9; k++)
            run_frame("R8", 2 + int'($urandom % 4), 1'b0, 1'b1, 1'b1, 2'($urandom % 4));
        chk(int'(crc_err_count) == CMAX, "R8", "counter saturated", crc_err_count, CMAX);

        finish_sim();
    end
endmodule